// File: doc/BRIEF.md
# Stop-Aware Reloadable Down Timer

This block is a down-counting periodic timer. Its count advances on a prescaled tick strobe. Software controls it through a small register bus. A reload register sets the period. An enable bit starts and stops counting. A sticky terminal-count flag drives the interrupt line. When the count is at zero and a tick arrives, the counter takes the reload value again and raises the flag. A period is therefore reload+1 ticks.

The timer also follows the chip's low-power stop mode. A one-cycle `stop_enter` strobe freezes the count, and ticks are ignored until a wake strobe arrives. The wake cause selects how the timer leaves stop:
- An interrupt wake resumes counting from the frozen value.
- A reset wake leaves stop with the timer disabled. The frozen value stays readable.

The CPU, the clock gating and the interrupt controller are outside the block. They appear only as input strobes.

Top module: `hrt_timer`

## Requirements
- R1: After synchronous reset the reload register, the count, the enable bit and the flag all read 0. The block is not in stop mode and `irq` is 0.
- R2: Bus map. Address 0 is the reload register (read/write). Address 1 is control: bit 0 is enable, bit 1 is the flag, and writing 1 to bit 1 clears the flag. Address 2 is the count (read-only). Read data is combinational from `bus_addr`.
- R3: While the timer is enabled and not stopped, each tick with a nonzero count lowers the count by exactly one.
- R4: A tick at count 0 (enabled, not stopped) loads the count from the reload register. On the following cycle the flag and `irq` are 1.
- R5: The flag stays set until a control write with bit 1 = 1. A control write with bit 1 = 0 leaves it set. If a terminal-count event and a clearing write fall in the same cycle, the flag stays set.
- R6: A reload write while the timer is disabled also loads the count with the written value. While the timer is enabled, a reload write changes only the reload register.
- R7: Ticks while the timer is disabled leave the count unchanged.
- R8: A `stop_enter` strobe enters stop mode. For the whole stop interval the count holds its value, whatever ticks arrive.
- R9: A `wake_irq` strobe during stop leaves stop mode. Counting resumes from exactly the held count, with the enable bit unchanged.
- R10: A `wake_rst` strobe during stop leaves stop mode and clears the enable bit, so later ticks leave the count at its held value. If both wake strobes come in the same cycle, the reset exit applies.
- R11: Wake strobes outside stop mode have no effect: the enable bit is kept and counting goes on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe from the prescaler |
| stop_enter | input | 1 | One-cycle request to enter stop mode |
| wake_irq | input | 1 | Stop exit caused by an interrupt |
| wake_rst | input | 1 | Stop exit caused by a reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| irq | output | 1 | Terminal-count interrupt (sticky flag) |

## Verification
The assertions check the following on every cycle:
- The count either decrements by one, reloads or holds; it never moves when the timer is idle or stopped.
- The flag rises after a terminal count and stays set without a clearing write.
- A reset exit always leaves the enable bit clear.
- Stop mode persists until a wake strobe, and wake strobes never move a running timer into or out of stop.

Only the bench's scenarios can show the end-to-end results. These are the exact count value held across a stop interval, and the difference between an interrupt wake, which resumes from that value, and a reset wake, which leaves it frozen and disabled. The scenarios also cover the set-beats-clear collision and the first-period load taken from a write while disabled.

// File: rtl/hrt_pkg.sv
package hrt_pkg;

    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_FLAG = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_RELOAD = 2'd0,
        A_CTRL   = 2'd1,
        A_COUNT  = 2'd2
    } hrt_addr_e;

    typedef struct packed {
        logic flag;
        logic en;
    } hrt_ctrl_t;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_IRQ,
        WK_RST
    } hrt_wake_e;

    // Reset exit takes priority over interrupt exit
    function automatic hrt_wake_e wake_cause(input logic irq_w, input logic rst_w);
        if (rst_w)      return WK_RST;
        else if (irq_w) return WK_IRQ;
        else            return WK_NONE;
    endfunction

endpackage

// File: rtl/hrt_stopctl.sv
module hrt_stopctl
    import hrt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_enter,
    input  logic wake_irq,
    input  logic wake_rst,
    output logic stopped,
    output logic rst_exit
);

    hrt_wake_e cause;

    always_comb begin
        cause    = stopped ? wake_cause(wake_irq, wake_rst) : WK_NONE;
        rst_exit = (cause == WK_RST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stopped <= 1'b0;
        end else if (cause != WK_NONE) begin
            stopped <= 1'b0;
        end else if (stop_enter) begin
            stopped <= 1'b1;
        end
    end

    // R9: an interrupt wake leaves stop
    p_irq_exit_r9: assert property (@(posedge clk) disable iff (rst)
        stopped && wake_irq && !wake_rst |=> !stopped);

    // R8: stop persists with no wake
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        stopped && !wake_irq && !wake_rst |=> stopped);

    // R11: wake strobes outside stop cannot enter stop
    p_wake_outside_r11: assert property (@(posedge clk) disable iff (rst)
        !stopped && !stop_enter |=> !stopped);

endmodule

// File: rtl/hrt_regs.sv
module hrt_regs
    import hrt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  hrt_addr_e        bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic             rst_exit,
    input  logic             tc_evt,
    output logic [CNT_W-1:0] reload,
    output hrt_ctrl_t        ctrl,
    output logic             load_req
);

    logic wr_reload;
    logic wr_ctrl;
    logic clr_req;

    always_comb begin
        wr_reload = bus_wr && (bus_addr == A_RELOAD);
        wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
        clr_req   = wr_ctrl && bus_wdata[BIT_FLAG];
        load_req  = wr_reload && !ctrl.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
        end else if (wr_reload) begin
            reload <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.en <= 1'b0;
        end else if (rst_exit) begin
            ctrl.en <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl.en <= bus_wdata[BIT_EN];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.flag <= 1'b0;
        end else if (tc_evt) begin
            ctrl.flag <= 1'b1;
        end else if (clr_req) begin
            ctrl.flag <= 1'b0;
        end
    end

    // R10: a reset exit leaves the timer disabled
    p_rst_exit_off_r10: assert property (@(posedge clk) disable iff (rst)
        rst_exit |=> !ctrl.en);

    // R4: terminal count raises the flag
    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        tc_evt |=> ctrl.flag);

    // R5: flag is sticky without a clearing write
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl.flag && !clr_req |=> ctrl.flag);

endmodule

// File: rtl/hrt_counter.sv
module hrt_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             tc_evt
);

    logic step;
    logic at_zero;

    always_comb begin
        step    = run && tick;
        at_zero = (count == '0);
        tc_evt  = step && at_zero && !load_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_req) begin
            count <= load_val;
        end else if (step) begin
            count <= at_zero ? reload : count - 1'b1;
        end
    end

    // R7/R8: without a step or load the count holds
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(run && tick) && !load_req |=> $stable(count));

    // R3: a step from nonzero decrements by one
    p_dec_r3: assert property (@(posedge clk) disable iff (rst)
        run && tick && (count != '0) && !load_req |=> count == $past(count) - 1'b1);

    // R4: a step from zero reloads
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        run && tick && (count == '0) && !load_req |=> count == $past(reload));

endmodule

// File: rtl/hrt_timer.sv
module hrt_timer
    import hrt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             stop_enter,
    input  logic             wake_irq,
    input  logic             wake_rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    hrt_addr_e        addr;
    logic             stopped;
    logic             rst_exit;
    logic             tc_evt;
    logic             load_req;
    logic             run;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    hrt_ctrl_t        ctrl;

    assign addr = hrt_addr_e'(bus_addr);

    hrt_stopctl u_stop (
        .clk        (clk),
        .rst        (rst),
        .stop_enter (stop_enter),
        .wake_irq   (wake_irq),
        .wake_rst   (wake_rst),
        .stopped    (stopped),
        .rst_exit   (rst_exit)
    );

    hrt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (addr),
        .bus_wdata (bus_wdata),
        .rst_exit  (rst_exit),
        .tc_evt    (tc_evt),
        .reload    (reload),
        .ctrl      (ctrl),
        .load_req  (load_req)
    );

    assign run = ctrl.en && !stopped;

    hrt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (run),
        .load_req (load_req),
        .load_val (bus_wdata),
        .reload   (reload),
        .count    (count),
        .tc_evt   (tc_evt)
    );

    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_RELOAD: bus_rdata = reload;
            A_CTRL:   begin
                bus_rdata[BIT_EN]   = ctrl.en;
                bus_rdata[BIT_FLAG] = ctrl.flag;
            end
            A_COUNT:  bus_rdata = count;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = ctrl.flag;

    // R1: nothing runs or flags in the cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        rst |=> !irq && !stopped && !ctrl.en);

endmodule

// File: tb/test_hrt_timer.sv
`timescale 1ns/1ps
module test_hrt_timer;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         stop_enter = 1'b0;
    logic         wake_irq = 1'b0;
    logic         wake_rst = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hrt_timer #(.CNT_W(W)) i_hrt_timer (
        .clk(clk), .rst(rst), .tick(tick), .stop_enter(stop_enter),
        .wake_irq(wake_irq), .wake_rst(wake_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] a, input int exp);
        int v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_enter = 1'b1;
        @(negedge clk); stop_enter = 1'b0;
    endtask

    task automatic pulse_wake(input logic wi, input logic wr_r);
        @(negedge clk); wake_irq = wi; wake_rst = wr_r;
        @(negedge clk); wake_irq = 1'b0; wake_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk_reg("R1 reload", 2'd0, 0);
        chk_reg("R1 ctrl", 2'd1, 0);
        chk_reg("R1 count", 2'd2, 0);
        check("R1 irq", int'(irq), 0);
    endtask

    task automatic t_period();
        wr(2'd0, 8'd5);
        chk_reg("R6 load while disabled", 2'd2, 5);
        ticks(3);
        chk_reg("R7 ticks while disabled", 2'd2, 5);
        wr(2'd1, 8'd1);
        chk_reg("R2 enable readback", 2'd1, 1);
        ticks(2);
        chk_reg("R3 decrement", 2'd2, 3);
        ticks(3);
        chk_reg("R3 reach zero", 2'd2, 0);
        check("R4 no flag before terminal tick", int'(irq), 0);
        ticks(1);
        chk_reg("R4 reload at zero", 2'd2, 5);
        check("R4 flag set", int'(irq), 1);
    endtask

    task automatic t_flag();
        wr(2'd1, 8'd1);
        check("R5 write 0 keeps flag", int'(irq), 1);
        wr(2'd1, 8'd3);
        check("R5 write 1 clears flag", int'(irq), 0);
        ticks(5);
        chk_reg("R3 count at zero", 2'd2, 0);
        @(negedge clk);
        tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'd3;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        check("R5 set beats clear", int'(irq), 1);
        chk_reg("R4 reload on collision", 2'd2, 5);
        wr(2'd1, 8'd3);
        check("R5 cleared again", int'(irq), 0);
    endtask

    task automatic t_reload_enabled();
        wr(2'd0, 8'd9);
        chk_reg("R6 count untouched while enabled", 2'd2, 5);
        chk_reg("R6 reload updated", 2'd0, 9);
        ticks(6);
        chk_reg("R4 new reload used", 2'd2, 9);
        wr(2'd1, 8'd3);
    endtask

    task automatic t_stop_irq();
        ticks(2);
        chk_reg("R3 before stop", 2'd2, 7);
        pulse_stop();
        ticks(4);
        chk_reg("R8 count held in stop", 2'd2, 7);
        pulse_wake(1'b1, 1'b0);
        chk_reg("R9 held value after irq wake", 2'd2, 7);
        chk_reg("R9 enable kept", 2'd1, 1);
        ticks(1);
        chk_reg("R9 resumed counting", 2'd2, 6);
    endtask

    task automatic t_stop_rst();
        pulse_stop();
        ticks(3);
        chk_reg("R8 held in second stop", 2'd2, 6);
        pulse_wake(1'b0, 1'b1);
        chk_reg("R10 enable cleared", 2'd1, 0);
        ticks(2);
        chk_reg("R10 count frozen after reset wake", 2'd2, 6);
        wr(2'd1, 8'd1);
        pulse_stop();
        pulse_wake(1'b1, 1'b1);
        chk_reg("R10 reset wins over irq wake", 2'd1, 0);
        wr(2'd1, 8'd1);
        ticks(1);
        chk_reg("R10 stop left after both wakes", 2'd2, 5);
    endtask

    task automatic t_wake_outside();
        pulse_wake(1'b0, 1'b1);
        chk_reg("R11 reset wake ignored outside stop", 2'd1, 1);
        ticks(1);
        chk_reg("R11 counting continues", 2'd2, 4);
        pulse_wake(1'b1, 1'b0);
        ticks(1);
        chk_reg("R11 irq wake ignored outside stop", 2'd2, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_period();
        t_flag();
        t_reload_enabled();
        t_stop_irq();
        t_stop_rst();
        t_wake_outside();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule